// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets synchronous logic read and write an external byte-wide asynchronous static RAM. A user-side request (strobe level, write flag, 19-bit address, write byte) starts one access. The controller then sequences active-low chip select, output enable and write enable, drives the address, and controls a split tri-state data bus (separate input, output and output-enable signals). A read returns its byte on `rdata` together with a one-cycle `done` pulse. A write also ends with a `done` pulse.

Every strobe width and gap is a down-counter load. Each load is computed at elaboration as ceil(time / clock period), with a minimum of one cycle. The times come from a speed-grade parameter: grade 0 is the 55 ns part, grade 1 the 70 ns part and grade 2 the 85 ns part. A standby input parks the memory with chip select inactive, for supply-drop retention. When it is released, a recovery wait of `RECOVERY_NS` passes before any access can start.

The state machine has seven states:
- IDLE waits for work.
- RD_ACCESS holds the read strobes.
- RD_TURN keeps the bus released while the memory's drivers turn off.
- WR_PULSE holds the write strobes and drives data.
- WR_RECOV pads the write cycle.
- STANDBY parks the memory.
- WAKE counts the recovery interval.

Its transitions are:
- IDLE→STANDBY when standby is requested; this has priority over a pending request.
- IDLE→RD_ACCESS or IDLE→WR_PULSE on a request.
- RD_ACCESS→RD_TURN, RD_TURN→IDLE, WR_PULSE→WR_RECOV, WR_RECOV→IDLE and WAKE→IDLE, each when its wait counter expires.
- STANDBY→WAKE when standby is released.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` and `done` are 0.
- R2: A read (request with `req_wr`=0) holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with the request address on `mem_addr` for exactly N_RD = ceil(max(read cycle, access time)/period) cycles. At the 55 ns grade with a 10 ns clock, N_RD is 6. On the edge that ends these cycles, the strobes rise, `rdata` takes the byte on `mem_dq_i`, and `done` is 1 for that one cycle.
- R3: A write (`req_wr`=1) holds `mem_cs_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 for exactly N_WP = ceil(max(write pulse, select-to-end, address-to-end, data setup)/period) cycles. N_WP is 5 at 55 ns and 10 ns. `mem_dq_oe` is 1 exactly while `mem_we_n` is 0, with the request byte on `mem_dq_o` and the request address on `mem_addr`.
- R4: After a write ends, chip select stays inactive for N_WR = max(1, ceil(write cycle/period) − N_WP) cycles before any new access can start its strobes. N_WR is 1 at 55 ns and 10 ns.
- R5: After a read ends, the controller does not drive the data bus and keeps all strobes inactive for N_HZ = ceil(output-disable-to-high-Z/period) cycles (2 at 55 ns and 10 ns). `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R6: `done` is never high for two cycles in a row. While an access is in progress, changes to `req_wr`, `req_addr` and `req_wdata` do not affect it, and they start no further access as long as `req` falls before the controller is idle again.
- R7: While `standby_req` is 1, from an idle controller, `mem_cs_n` stays 1 and requests are not served.
- R8: After `standby_req` falls, no access strobe appears for N_REC = ceil(`RECOVERY_NS`/period) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request level, sampled when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| standby_req | input | 1 | Enter retention standby |
| rdata | output | 8 | Byte returned by the last read |
| done | output | 1 | One-cycle end-of-access pulse |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_i | input | 8 | Data read from the memory bus |

## Verification
The hardest conditions to reach are the minimum gaps between accesses: the bus-release gap after a read and the pad after a write. They only show when the next request is already waiting on the cycle `done` appears. The bench issues the next request on that same cycle, and in random runs follows `done` with idle gaps of zero to three cycles, so each gap is measured both when it is cut short and when it is fully visible. Standby is entered with a request already pending, and released on the very cycle the request is reissued, so the full recovery interval is counted.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_WR_PULSE,
        ST_WR_RECOV,
        ST_STANDBY,
        ST_WAKE
    } asram_state_e;

    // Timing set of one speed grade, all in nanoseconds.
    typedef struct packed {
        int unsigned cycle_ns;   // read and write cycle minimum, also access maximum
        int unsigned oe_acc_ns;  // output enable to valid data
        int unsigned oe_hz_ns;   // output disable to high impedance
        int unsigned wpulse_ns;  // write pulse minimum
        int unsigned cs_end_ns;  // chip select to end of write
        int unsigned adr_end_ns; // address valid to end of write
        int unsigned dsetup_ns;  // data valid before end of write
    } grade_times_t;

    function automatic grade_times_t grade_times(input int unsigned grade);
        grade_times_t g;
        case (grade)
            1:       g = '{cycle_ns: 70, oe_acc_ns: 35, oe_hz_ns: 25, wpulse_ns: 55,
                           cs_end_ns: 60, adr_end_ns: 60, dsetup_ns: 30};
            2:       g = '{cycle_ns: 85, oe_acc_ns: 40, oe_hz_ns: 25, wpulse_ns: 55,
                           cs_end_ns: 70, adr_end_ns: 70, dsetup_ns: 35};
            default: g = '{cycle_ns: 55, oe_acc_ns: 25, oe_hz_ns: 20, wpulse_ns: 40,
                           cs_end_ns: 45, adr_end_ns: 45, dsetup_ns: 25};
        endcase
        return g;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Whole clock cycles covering a time, never fewer than one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned period_ns);
        int unsigned r;
        r = (t_ns + period_ns - 1) / period_ns;
        return (r < 1) ? 1 : r;
    endfunction

endpackage

// File: rtl/asram_wait_cnt.sv
module asram_wait_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/asram_pin_drv.sv
module asram_pin_drv #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_on,
    input  logic          oe_on,
    input  logic          we_on,
    input  logic          drive_on,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          data_load,
    input  logic [DW-1:0] data_in,
    output logic          cs_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          dq_oe,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] dq_q
);

    // Strobes leave a flop so the memory pins never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs_n  <= ~cs_on;
            oe_n  <= ~oe_on;
            we_n  <= ~we_on;
            dq_oe <= drive_on;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            dq_q   <= '0;
        end else begin
            if (addr_load) addr_q <= addr_in;
            if (data_load) dq_q   <= data_in;
        end
    end

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= bus_in;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int unsigned RECOVERY_NS   = 5000000,
    parameter int          ADDR_W        = 19,
    parameter int          DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              standby_req,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    import asram_pkg::*;

    localparam grade_times_t GT = grade_times(SPEED_GRADE);
    localparam int unsigned N_RD  = ns_to_cyc(umax(GT.cycle_ns, GT.oe_acc_ns), CLK_PERIOD_NS);
    localparam int unsigned N_WP  = ns_to_cyc(umax(umax(GT.wpulse_ns, GT.cs_end_ns),
                                                   umax(GT.adr_end_ns, GT.dsetup_ns)), CLK_PERIOD_NS);
    localparam int unsigned N_WC  = ns_to_cyc(GT.cycle_ns, CLK_PERIOD_NS);
    localparam int unsigned N_WR  = (N_WC > N_WP) ? (N_WC - N_WP) : 1;
    localparam int unsigned N_HZ  = ns_to_cyc(GT.oe_hz_ns, CLK_PERIOD_NS);
    localparam int unsigned N_REC = ns_to_cyc(RECOVERY_NS, CLK_PERIOD_NS);
    localparam int unsigned N_MAX = umax(umax(N_RD, N_WP), umax(umax(N_WR, N_HZ), N_REC));
    localparam int          CW    = $clog2(N_MAX + 1);

    asram_state_e state, state_nxt;
    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;
    logic          capture;
    logic          cs_on, oe_on, we_on, drive_on;
    logic          start_acc;
    logic          done_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state and wait loads
    always_comb begin
        state_nxt = state;
        load      = 1'b0;
        load_val  = '0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (standby_req) begin
                    state_nxt = ST_STANDBY;
                end else if (req) begin
                    load = 1'b1;
                    if (req_wr) begin
                        state_nxt = ST_WR_PULSE;
                        load_val  = CW'(N_WP - 1);
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        load_val  = CW'(N_RD - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (expired) begin
                    state_nxt = ST_RD_TURN;
                    load      = 1'b1;
                    load_val  = CW'(N_HZ - 1);
                    capture   = 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (expired) state_nxt = ST_IDLE;
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    state_nxt = ST_WR_RECOV;
                    load      = 1'b1;
                    load_val  = CW'(N_WR - 1);
                end
            end
            ST_WR_RECOV: begin
                if (expired) state_nxt = ST_IDLE;
            end
            ST_STANDBY: begin
                if (!standby_req) begin
                    state_nxt = ST_WAKE;
                    load      = 1'b1;
                    load_val  = CW'(N_REC - 1);
                end
            end
            ST_WAKE: begin
                if (expired) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Output decode from the state being entered
    always_comb begin
        cs_on     = (state_nxt == ST_RD_ACCESS) || (state_nxt == ST_WR_PULSE);
        oe_on     = (state_nxt == ST_RD_ACCESS);
        we_on     = (state_nxt == ST_WR_PULSE);
        drive_on  = (state_nxt == ST_WR_PULSE);
        start_acc = (state == ST_IDLE) && cs_on;
        done_nxt  = ((state == ST_RD_ACCESS) && (state_nxt == ST_RD_TURN)) ||
                    ((state == ST_WR_PULSE)  && (state_nxt == ST_WR_RECOV));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= done_nxt;
    end

    asram_wait_cnt #(.W(CW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    asram_pin_drv #(.AW(ADDR_W), .DW(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_on     (cs_on),
        .oe_on     (oe_on),
        .we_on     (we_on),
        .drive_on  (drive_on),
        .addr_load (start_acc),
        .addr_in   (req_addr),
        .data_load (start_acc && req_wr),
        .data_in   (req_wdata),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (mem_dq_oe),
        .addr_q    (mem_addr),
        .dq_q      (mem_dq_o)
    );

    asram_rd_capture #(.DW(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .bus_in  (mem_dq_i),
        .rdata   (rdata)
    );

endmodule

// File: rtl/asram_ctrl_checks.sv
module asram_ctrl_checks #(
    parameter int unsigned N_RD = 6,
    parameter int unsigned N_WP = 5,
    parameter int unsigned N_WR = 1,
    parameter int unsigned N_HZ = 2
) (
    input logic clk,
    input logic rst_n,
    input logic standby_req,
    input logic done,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe
);

    logic [15:0] low_len;
    logic [15:0] since_oe;
    logic [15:0] since_we;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_len  <= '0;
            since_oe <= 16'(N_HZ);
            since_we <= 16'(N_WR);
        end else begin
            low_len <= mem_cs_n ? 16'd0 : low_len + 16'd1;
            if (!mem_oe_n)                  since_oe <= '0;
            else if (since_oe < 16'(N_HZ))  since_oe <= since_oe + 16'd1;
            if (!mem_we_n)                  since_we <= '0;
            else if (since_we < 16'(N_WR))  since_we <= since_we + 16'd1;
        end
    end

    assert_read_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) && $past(!mem_oe_n) |-> low_len == 16'(N_RD));

    assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_cs_n && mem_oe_n && mem_we_n);

    assert_write_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) && $past(!mem_we_n) |-> low_len == 16'(N_WP));

    assert_drive_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n && !mem_cs_n && mem_oe_n);

    assert_write_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> since_we >= 16'(N_WR));

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> since_oe >= 16'(N_HZ));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_standby_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        standby_req && mem_cs_n |=> mem_cs_n);

endmodule

bind asram_ctrl asram_ctrl_checks #(
    .N_RD (N_RD),
    .N_WP (N_WP),
    .N_WR (N_WR),
    .N_HZ (N_HZ)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_req (standby_req),
    .done        (done),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

    localparam int PER    = 10;
    localparam int REC_NS = 300;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, req_wr, standby_req;
    logic [18:0] req_addr;
    logic [7:0]  req_wdata;
    logic [7:0]  rdata;
    logic        done;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(PER/2) clk = ~clk;

    asram_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(0), .RECOVERY_NS(REC_NS)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .standby_req(standby_req), .rdata(rdata), .done(done),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    function automatic int cyc(input int t);
        int r = (t + PER - 1) / PER;
        return (r < 1) ? 1 : r;
    endfunction

    // Expected waits for the 55 ns grade, from the requirements
    localparam int E_RD  = (55 + PER - 1) / PER;
    localparam int E_WP  = (45 + PER - 1) / PER;
    localparam int E_HZ  = (20 + PER - 1) / PER;
    localparam int E_WR  = ((55 + PER - 1) / PER > E_WP) ? (55 + PER - 1) / PER - E_WP : 1;
    localparam int E_REC = (REC_NS + PER - 1) / PER;

    function automatic logic [7:0] fill(input logic [18:0] a);
        return a[7:0] ^ {a[14:11], a[18:15]} ^ 8'h5A;
    endfunction

    // Memory seen at the pins
    logic [7:0] pin_mem [int];
    always @(negedge clk) begin
        if (!mem_cs_n && !mem_we_n && mem_dq_oe) pin_mem[int'(mem_addr)] = mem_dq_o;
        mem_dq_i = pin_mem.exists(int'(mem_addr)) ? pin_mem[int'(mem_addr)] : fill(mem_addr);
    end

    // Expected memory contents
    logic [7:0] exp_mem [int];
    function automatic logic [7:0] model(input logic [18:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : fill(a);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    int prev_base = 0;  // gap owed by the previous access

    task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d, input int exp_pre);
        int  pre  = 0;
        int  lo   = 0;
        int  bad  = 0;
        bit  seen = 0;
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            if (done) break;
            if (!mem_cs_n) begin
                seen = 1;
                lo++;
                if (wr) begin
                    if (!(!mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_o == d && mem_addr == a)) bad++;
                end else begin
                    if (!(mem_we_n && !mem_oe_n && !mem_dq_oe && mem_addr == a)) bad++;
                end
            end else if (!seen) begin
                pre++;
            end
        end
        req = 1'b0;
        check(pre == exp_pre, (exp_pre > E_WR) ? "R5/R8 gap" : "R4/R5 gap", pre, exp_pre);
        if (wr) begin
            check(lo == E_WP, "R3 write strobe width", lo, E_WP);
            check(bad == 0, "R3 write pins", bad, 0);
            exp_mem[int'(a)] = d;
            prev_base = E_WR;
        end else begin
            check(lo == E_RD, "R2 read strobe width", lo, E_RD);
            check(bad == 0, "R2 read pins", bad, 0);
            check(rdata == model(a), "R2 read data", rdata, model(a));
            prev_base = E_HZ;
        end
    endtask

    initial begin
        int bad;
        logic [7:0] ra;
        rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; standby_req = 1'b0;
        req_addr = '0; req_wdata = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset values
        check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes in reset",
              {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        check(!mem_dq_oe && !done, "R1 drive/done in reset", {mem_dq_oe, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: extremes and back-to-back turnaround
        access(1, 19'h7FFFF, 8'hA5, 0);
        access(0, 19'h7FFFF, 8'h00, E_WR);   // R4 pad after write
        access(1, 19'h00000, 8'h3C, E_HZ);   // R5 release after read
        access(0, 19'h00000, 8'h00, E_WR);
        access(0, 19'h12345, 8'h00, E_HZ);   // unwritten
        repeat (3) @(negedge clk);

        // R6: request fields changed mid-read are ignored
        bad = 0;
        req = 1'b1; req_wr = 1'b0; req_addr = 19'h00100;
        repeat (2) @(negedge clk);
        req_wr = 1'b1; req_addr = 19'h00200; req_wdata = 8'hFF;
        while (!done) begin
            if (!mem_we_n || (!mem_cs_n && mem_addr != 19'h00100)) bad++;
            @(negedge clk);
        end
        ra = rdata;
        req = 1'b0;
        check(ra == model(19'h00100), "R6 read kept original address", ra, model(19'h00100));
        @(negedge clk);
        check(!done, "R6 done single cycle", done, 0);
        repeat (8) begin
            if (!mem_we_n || !mem_cs_n) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6 no extra access", bad, 0);
        access(0, 19'h00200, 8'h00, 0);      // R6 B still holds fill value

        // R7 / R8 standby with pending request
        repeat (3) @(negedge clk);
        standby_req = 1'b1; req = 1'b1; req_wr = 1'b0; req_addr = 19'h00044;
        bad = 0;
        repeat (12) begin
            @(negedge clk);
            if (!mem_cs_n || done) bad++;
        end
        check(bad == 0, "R7 standby blocks access", bad, 0);
        standby_req = 1'b0;
        access(0, 19'h00044, 8'h00, E_REC + 1);  // R8 recovery

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int gap = int'($urandom % 4);
            int ep;
            bit w = $urandom % 2;
            logic [18:0] a = 19'h3FF00 + 19'($urandom % 16);
            if (($urandom % 16) == 0) a = 19'h7FFFF;
            repeat (gap) @(negedge clk);
            ep = (prev_base > gap) ? prev_base - gap : 0;
            access(w, a, 8'($urandom), ep);
        end

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule